// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is the register-side logic of one 8-pin general-purpose I/O port. Software reaches it through a small memory-mapped register bus: an address, a write strobe, write data and combinational read data. Five 8-bit registers set the port up, with one bit for each pin. They select the direction, expose the pin levels, hold the driven output value, enable a weak pull-up, and switch a pin between analog and digital use.

For each pin the block drives three pad controls: the output data, the output enable and the pull-up request. It receives one raw input level for each pin. The input level passes through a two-flop synchronizer before the port register can read it. A pin set to analog mode has its digital input path held inactive, so the port register reads that pin as 0.

After reset every pin is an input, nothing is driven, and every pull-up is off. Each analog-capable pin starts in analog mode. A parameter mask selects which pins are analog-capable.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and after it, the registers hold their reset values. Direction reads 0xFF, the latch reads 0x00, pull-up enable reads 0x00 and analog select reads the analog-capable mask (0x0F by default). pad_oe, pad_out and pad_pu are all 0x00.
- R2: The direction register is at address 2, and a direction bit of 1 makes its pin an input. pad_oe is the bitwise inverse of the direction register.
- R3: The output latch is at address 1. It can be written and read back there, and pad_out always equals the latch.
- R4: A write to address 0 updates the output latch. A read of address 0 returns the synchronized pin levels and never returns the latch.
- R5: A change on pad_in shows in an address-0 read after the second rising clock edge and not after the first.
- R6: An address-0 read returns 0 for every pin whose analog-select bit is 1, whatever the pin level is.
- R7: The analog-select register is at address 4. Only the analog-capable bits (mask 0x0F) can be written, and the other bits always read 0.
- R8: The pull-up enable register is at address 3. pad_pu for a pin is 1 only when its pull-up bit is 1 and the pin is an input.
- R9: Addresses 5 to 7 read as 0x00, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Value driven on output pins |
| pad_oe | output | 8 | Output enable for each pin |
| pad_pu | output | 8 | Weak pull-up request for each pin |

## Verification
The port read path is tested with complementary pin patterns (0xA5, 0x3C, 0xFF) while the analog select is all zeros, half set and re-set. This separates reading the real pin level from reading the latch, and separates masked analog pins from live digital ones. A port write is followed by a port read with different pin levels, which separates the write target from the read source. A split direction setting with every pull-up enabled separates correct pull-up gating from ungated pull-ups. Single-edge sampling after a pin change separates a two-stage synchronizer from a shorter one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned SEL_W  = 3;

  // Register select codes; the bench and software rely on these values.
  typedef enum logic [SEL_W-1:0] {
    SEL_PIN  = 3'd0,
    SEL_LAT  = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_PULL = 3'd3,
    SEL_ANA  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] block_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] gated;
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  // A blocked (analog) pin keeps its digital buffer output low.
  always_comb begin
    gated = raw_i & ~block_i;
  end

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = gated;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= stg_d[s];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH    = PORT_W,
  parameter logic [WIDTH-1:0] ANA_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] lat_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] pull_o,
  output logic [WIDTH-1:0] ana_o
);

  localparam logic [WIDTH-1:0] DIR_RST = '1;

  logic [WIDTH-1:0] lat_q,  lat_d;
  logic [WIDTH-1:0] dir_q,  dir_d;
  logic [WIDTH-1:0] pull_q, pull_d;
  logic [WIDTH-1:0] ana_q,  ana_d;

  logic lat_en, dir_en, pull_en, ana_en;

  // Write decode: the port address and the latch address both land in the latch.
  always_comb begin
    lat_en  = we_i && ((sel_i == SEL_PIN) || (sel_i == SEL_LAT));
    dir_en  = we_i && (sel_i == SEL_DIR);
    pull_en = we_i && (sel_i == SEL_PULL);
    ana_en  = we_i && (sel_i == SEL_ANA);
  end

  always_comb begin
    lat_d  = lat_en  ? wdata_i : lat_q;
    dir_d  = dir_en  ? wdata_i : dir_q;
    pull_d = pull_en ? wdata_i : pull_q;
    ana_d  = ana_en  ? (wdata_i & ANA_MASK) : ana_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= DIR_RST;
      pull_q <= '0;
      ana_q  <= ANA_MASK;
    end else begin
      lat_q  <= lat_d;
      dir_q  <= dir_d;
      pull_q <= pull_d;
      ana_q  <= ana_d;
    end
  end

  assign lat_o  = lat_q;
  assign dir_o  = dir_q;
  assign pull_o = pull_q;
  assign ana_o  = ana_q;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_DIR) |=> (dir_o == $past(wdata_i)));

  // R4
  port_write_to_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_PIN) |=> (lat_o == $past(wdata_i)));

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_LAT) |=> (lat_o == $past(wdata_i)));

  // R7
  ana_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_o & ~ANA_MASK) == '0);

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i > SEL_ANA) |=> ($stable(lat_o) && $stable(dir_o) &&
                                   $stable(pull_o) && $stable(ana_o)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] pull_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pu_o
);

  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pin
      // Direction bit 1 = input; the pull-up is only offered to inputs.
      always_comb begin
        out_o[p] = lat_i[p];
        oe_o[p]  = ~dir_i[p];
        pu_o[p]  = pull_i[p] & dir_i[p];
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH       = PORT_W,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      RST_STAGES  = 2,
  parameter logic [WIDTH-1:0] ANA_MASK    = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  logic             rst_n_int;
  logic [WIDTH-1:0] lat, dir, pull, ana;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] pin_view;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_ctrl_regs #(.WIDTH(WIDTH), .ANA_MASK(ANA_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (bus_we),
    .sel_i   (bus_addr),
    .wdata_i (bus_wdata),
    .lat_o   (lat),
    .dir_o   (dir),
    .pull_o  (pull),
    .ana_o   (ana)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .raw_i   (pad_in),
    .block_i (ana),
    .sync_o  (pin_sync)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .lat_i  (lat),
    .dir_i  (dir),
    .pull_i (pull),
    .out_o  (pad_out),
    .oe_o   (pad_oe),
    .pu_o   (pad_pu)
  );

  // Masking here as well removes the pipeline delay when a pin turns analog.
  always_comb begin
    pin_view = pin_sync & ~ana;
  end

  always_comb begin
    case (bus_addr)
      SEL_PIN:  bus_rdata = pin_view;
      SEL_LAT:  bus_rdata = lat;
      SEL_DIR:  bus_rdata = dir;
      SEL_PULL: bus_rdata = pull;
      SEL_ANA:  bus_rdata = ana;
      default:  bus_rdata = '0;
    endcase
  end

  // R6
  analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_addr == SEL_PIN) |-> ((bus_rdata & ana) == '0));

  // R8
  pullup_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pad_pu & pad_oe) == '0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_addr > SEL_ANA) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] pad_pu;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_port_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic       we;
    logic [7:0] wd;
    logic [7:0] pins;
    logic [7:0] rd;
    logic [7:0] oe;
    logic [7:0] pu;
    logic [7:0] out;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b1, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 4'd7}, // R7 clear analog
    '{3'd0, 1'b0, 8'h00, 8'hA5, 8'hA5, 8'h00, 8'h00, 8'h00, 4'd4}, // R4 pin read
    '{3'd0, 1'b0, 8'h00, 8'h3C, 8'h3C, 8'h00, 8'h00, 8'h00, 4'd4}, // R4 pin read
    '{3'd3, 1'b1, 8'hFF, 8'h3C, 8'hFF, 8'h00, 8'hFF, 8'h00, 4'd8}, // R8 all pull-ups
    '{3'd2, 1'b1, 8'h0F, 8'h3C, 8'h0F, 8'hF0, 8'h0F, 8'h00, 4'd2}, // R2 upper outputs
    '{3'd0, 1'b1, 8'h96, 8'h3C, 8'h3C, 8'hF0, 8'h0F, 8'h96, 4'd4}, // R4 write lands in latch
    '{3'd1, 1'b0, 8'h00, 8'h3C, 8'h96, 8'hF0, 8'h0F, 8'h96, 4'd3}, // R3 latch read back
    '{3'd4, 1'b1, 8'hFF, 8'h3C, 8'h0F, 8'hF0, 8'h0F, 8'h96, 4'd7}, // R7 mask
    '{3'd0, 1'b0, 8'h00, 8'hFF, 8'hF0, 8'hF0, 8'h0F, 8'h96, 4'd6}, // R6 analog zero
    '{3'd5, 1'b1, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h96, 4'd9}, // R9 unmapped
    '{3'd2, 1'b0, 8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h0F, 8'h96, 4'd9}, // R9 dir unchanged
    '{3'd1, 1'b1, 8'h5A, 8'h00, 8'h5A, 8'hF0, 8'h0F, 8'h5A, 4'd3}  // R3 direct latch write
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic read_at(input logic [2:0] a, input int req, input string what, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, what, bus_rdata, exp);
  endtask

  task automatic check_reset_values(input string tag);
    // R1
    chk(1, {tag, " pad_oe"},  pad_oe,  8'h00);
    chk(1, {tag, " pad_out"}, pad_out, 8'h00);
    chk(1, {tag, " pad_pu"},  pad_pu,  8'h00);
    read_at(3'd2, 1, {tag, " dir"},    8'hFF);
    read_at(3'd1, 1, {tag, " latch"},  8'h00);
    read_at(3'd3, 1, {tag, " pull"},   8'h00);
    read_at(3'd4, 1, {tag, " analog"}, 8'h0F);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = 3'd0;
    bus_we    = 1'b0;
    bus_wdata = 8'h00;
    pad_in    = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_reset_values("post-reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_addr  = VECS[i].addr;
      bus_we    = VECS[i].we;
      bus_wdata = VECS[i].wd;
      pad_in    = VECS[i].pins;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(VECS[i].req, $sformatf("vec%0d rdata", i),   bus_rdata, VECS[i].rd);
      chk(VECS[i].req, $sformatf("vec%0d pad_oe", i),  pad_oe,    VECS[i].oe);
      chk(VECS[i].req, $sformatf("vec%0d pad_pu", i),  pad_pu,    VECS[i].pu);
      chk(VECS[i].req, $sformatf("vec%0d pad_out", i), pad_out,   VECS[i].out);
    end

    // R5: two-edge synchronizer latency
    @(negedge clk);
    bus_addr  = 3'd4;
    bus_we    = 1'b1;
    bus_wdata = 8'h00;
    pad_in    = 8'h00;
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = 3'd0;
    repeat (3) @(negedge clk);
    chk(5, "settled low", bus_rdata, 8'h00);
    pad_in = 8'hFF;
    @(negedge clk);
    chk(5, "after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    chk(5, "after two edges", bus_rdata, 8'hFF);

    // R6: turning a pin analog masks it at once
    bus_addr  = 3'd4;
    bus_we    = 1'b1;
    bus_wdata = 8'h05;
    @(negedge clk);
    bus_we = 1'b0;
    read_at(3'd0, 6, "analog 0x05 mask", 8'hFA);

    // R1: asynchronous reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_values("mid-reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_values("re-released");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule